// File: doc/BRIEF.md
# Compressed Program and Data Trace Encoder

This block turns per-cycle execution activity into a stream of short trace messages. It takes three kinds of input:
- retired-instruction strobes, each with a branch flag and a branch target;
- data accesses, each with an address, a value and a write/read flag;
- instrumentation writes, each carrying a value only.

Program flow is not sent instruction by instruction. The encoder counts sequential (non-branch) retirements. It emits one branch message when a branch retires, or when the count reaches a configurable limit.

Data messages send the address as a signed difference from the previous data message. Instrumentation messages carry only the value. Data and instrumentation messages leave as soon as they occur. Program information waits until its message is complete. A data access can therefore appear on the stream ahead of the program message that covers the instruction that made it.

The output is a valid/ready message stream. Two single-entry holding slots sit behind the output:
- a side slot for data and instrumentation messages;
- a program slot for branch messages.

An output state machine has three states:
- `OS_IDLE`: nothing is presented.
- `OS_SIDE`: the side slot is presented.
- `OS_PROG`: the program slot is presented.

It moves between them with these transitions:
- **stall**: the presented message stays while ready is low.
- **pick-side**: after a handshake or from idle, go to `OS_SIDE` whenever the side slot will be occupied.
- **pick-prog**: otherwise, go to `OS_PROG` if the program slot will be occupied.
- **drain**: otherwise, go to `OS_IDLE`.

Top module: `trace_encoder`

## Requirements
- R1: While reset is held and in the first cycle after it, `msg_valid` and `err` are 0.
- R2: A retiring branch produces a message with `msg_type`=2'b00, `msg_flag`=0, `msg_addr` = branch target, and `msg_data` = number of non-branch retirements since the previous program message (or since trace enable). The branch itself is not counted.
- R3: When a non-branch retirement brings the count to `MAX_SEQ` (default 500), a message with `msg_type`=2'b00, `msg_flag`=1, `msg_addr`=0 and `msg_data`=`MAX_SEQ` is produced, and counting restarts from 0.
- R4: A data access produces `msg_type`=2'b01 for a write or 2'b10 for a read, with `msg_data` = the access value. The first data message after reset or after trace enable rises carries `msg_flag`=1 and the absolute address. Later ones carry `msg_flag`=0 and address minus previous accepted data address, modulo 2^AW.
- R5: An instrumentation write produces `msg_type`=2'b11, with `msg_data` = the value zero-extended, `msg_addr`=0 and `msg_flag`=0. It does not change the base used for data deltas.
- R6: When a data or instrumentation message and a completed program message arise in the same cycle, the data or instrumentation message is presented first.
- R7: With the output idle, an event's message is presented with `msg_valid`=1 in the cycle after the event.
- R8: While `msg_valid`=1 and `msg_ready`=0, the presented message and its fields stay unchanged in the next cycle.
- R9: `err` pulses in the cycle after either of these:
  - an event that finds its slot occupied and not draining; the event is dropped, and a dropped data access leaves the delta base unchanged;
  - a data access and an instrumentation write in the same cycle; the data access is kept and the instrumentation write is dropped.
- R10: While `trace_en`=0, all events are ignored, the sequential count is cleared and the delta base is invalidated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Trace enable |
| ret_vld | input | 1 | Instruction retired this cycle |
| ret_branch | input | 1 | Retired instruction is a taken branch |
| ret_target | input | AW | Branch target address |
| mem_vld | input | 1 | Data access this cycle |
| mem_write | input | 1 | 1 = write, 0 = read |
| mem_addr | input | AW | Data access address |
| mem_data | input | DW | Data access value |
| inst_vld | input | 1 | Instrumentation write this cycle |
| inst_value | input | IW | Instrumentation value |
| msg_ready | input | 1 | Downstream accepts message |
| msg_valid | output | 1 | Message presented |
| msg_type | output | 2 | 00 branch, 01 write, 10 read, 11 instrumentation |
| msg_flag | output | 1 | Branch: count-limit message; data: absolute address |
| msg_addr | output | AW | Target, address/delta, or 0 |
| msg_data | output | DW | Count, access value or instrumentation value |
| err | output | 1 | Event could not be absorbed |

## Verification
A wrong sequential count stays hidden until the next program message, which may be up to `MAX_SEQ` retirements later. At that point it shows as a wrong `msg_data` on a type-00 message. A corrupted delta base shows on the very next data message as a wrong `msg_addr`, so the bench follows a data access with another one and also runs a dropped access. A slot or state-register fault shows within one handshake: as a lost, duplicated or reordered message on the stream, or as an `err` pulse missing or misplaced by a cycle.

// File: rtl/trace_enc_pkg.sv
package trace_enc_pkg;
    typedef enum logic [1:0] {
        MK_BRANCH = 2'b00,
        MK_WRITE  = 2'b01,
        MK_READ   = 2'b10,
        MK_INSTR  = 2'b11
    } msg_kind_e;

    typedef enum logic [1:0] {
        OS_IDLE = 2'b00,
        OS_SIDE = 2'b01,
        OS_PROG = 2'b10
    } out_state_e;
endpackage

// File: rtl/trc_prog_tracker.sv
module trc_prog_tracker #(
    parameter int AW      = 32,
    parameter int MAX_SEQ = 500,
    parameter int CW      = $clog2(MAX_SEQ + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          ret,
    input  logic          br,
    input  logic [AW-1:0] tgt,
    output logic          done,
    output logic          flush,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_SEQ);

    logic [CW-1:0] seq_q;
    logic          limit_hit;

    assign limit_hit = (seq_q == LIMIT - 1'b1);

    always_comb begin
        done  = en & ret & (br | limit_hit);
        flush = en & ret & ~br & limit_hit;
        addr  = br ? tgt : '0;
        cnt   = br ? seq_q : LIMIT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else if (!en) begin
            seq_q <= '0;
        end else if (ret) begin
            seq_q <= (br || limit_hit) ? '0 : seq_q + 1'b1;
        end
    end
endmodule

// File: rtl/trc_side_encoder.sv
module trc_side_encoder
    import trace_enc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          dat_vld,
    input  logic          dat_wr,
    input  logic [AW-1:0] dat_addr,
    input  logic [DW-1:0] dat_val,
    input  logic          itm_vld,
    input  logic [IW-1:0] itm_val,
    input  logic          room,
    output logic          evt,
    output logic          clash,
    output msg_kind_e     kind,
    output logic          abs,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    logic [AW-1:0] base_q;
    logic          base_ok_q;
    logic          take_dat;
    logic          take_itm;

    always_comb begin
        take_dat = en & dat_vld;
        take_itm = en & itm_vld & ~dat_vld;
        evt      = take_dat | take_itm;
        clash    = en & dat_vld & itm_vld;
        if (take_dat) begin
            kind = dat_wr ? MK_WRITE : MK_READ;
            abs  = ~base_ok_q;
            addr = base_ok_q ? (dat_addr - base_q) : dat_addr;
            data = dat_val;
        end else begin
            kind = MK_INSTR;
            abs  = 1'b0;
            addr = '0;
            data = DW'(itm_val);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            base_ok_q <= 1'b0;
        end else if (!en) begin
            base_ok_q <= 1'b0;
        end else if (take_dat && room) begin
            base_q    <= dat_addr;
            base_ok_q <= 1'b1;
        end
    end
endmodule

// File: rtl/trc_out_arbiter.sv
module trc_out_arbiter
    import trace_enc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          side_evt,
    input  logic          side_clash,
    input  msg_kind_e     side_kind,
    input  logic          side_abs,
    input  logic [AW-1:0] side_addr,
    input  logic [DW-1:0] side_data,
    input  logic          prog_evt,
    input  logic          prog_flush,
    input  logic [AW-1:0] prog_addr,
    input  logic [DW-1:0] prog_data,
    input  logic          msg_ready,
    output logic          side_room,
    output logic          msg_valid,
    output msg_kind_e     msg_type,
    output logic          msg_flag,
    output logic [AW-1:0] msg_addr,
    output logic [DW-1:0] msg_data,
    output logic          err
);
    out_state_e    state_q, state_d, pick;
    logic          s_full, p_full;
    msg_kind_e     s_kind;
    logic          s_flag, p_flag;
    logic [AW-1:0] s_addr, p_addr;
    logic [DW-1:0] s_data, p_data;
    logic          side_take, prog_take, prog_room;
    logic          side_load, prog_load, s_full_d, p_full_d, drop;

    always_comb begin
        side_take = (state_q == OS_SIDE) & msg_ready;
        prog_take = (state_q == OS_PROG) & msg_ready;
        side_room = ~s_full | side_take;
        prog_room = ~p_full | prog_take;
        side_load = side_evt & side_room;
        prog_load = prog_evt & prog_room;
        s_full_d  = side_load | (s_full & ~side_take);
        p_full_d  = prog_load | (p_full & ~prog_take);
        drop      = (side_evt & ~side_room) | (prog_evt & ~prog_room) | side_clash;
        pick      = s_full_d ? OS_SIDE : (p_full_d ? OS_PROG : OS_IDLE);
        unique case (state_q)
            OS_IDLE: state_d = pick;
            OS_SIDE: state_d = side_take ? pick : OS_SIDE;
            OS_PROG: state_d = prog_take ? pick : OS_PROG;
            default: state_d = OS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_full <= 1'b0;
            p_full <= 1'b0;
            err    <= 1'b0;
            s_kind <= MK_INSTR;
            s_flag <= 1'b0;
            s_addr <= '0;
            s_data <= '0;
            p_flag <= 1'b0;
            p_addr <= '0;
            p_data <= '0;
        end else begin
            s_full <= s_full_d;
            p_full <= p_full_d;
            err    <= drop;
            if (side_load) begin
                s_kind <= side_kind;
                s_flag <= side_abs;
                s_addr <= side_addr;
                s_data <= side_data;
            end
            if (prog_load) begin
                p_flag <= prog_flush;
                p_addr <= prog_addr;
                p_data <= prog_data;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            OS_SIDE: begin
                msg_valid = 1'b1;
                msg_type  = s_kind;
                msg_flag  = s_flag;
                msg_addr  = s_addr;
                msg_data  = s_data;
            end
            OS_PROG: begin
                msg_valid = 1'b1;
                msg_type  = MK_BRANCH;
                msg_flag  = p_flag;
                msg_addr  = p_addr;
                msg_data  = p_data;
            end
            default: begin
                msg_valid = 1'b0;
                msg_type  = MK_BRANCH;
                msg_flag  = 1'b0;
                msg_addr  = '0;
                msg_data  = '0;
            end
        endcase
    end
endmodule

// File: rtl/trace_encoder.sv
module trace_encoder
    import trace_enc_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int IW      = 16,
    parameter int MAX_SEQ = 500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trace_en,
    input  logic          ret_vld,
    input  logic          ret_branch,
    input  logic [AW-1:0] ret_target,
    input  logic          mem_vld,
    input  logic          mem_write,
    input  logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_data,
    input  logic          inst_vld,
    input  logic [IW-1:0] inst_value,
    input  logic          msg_ready,
    output logic          msg_valid,
    output logic [1:0]    msg_type,
    output logic          msg_flag,
    output logic [AW-1:0] msg_addr,
    output logic [DW-1:0] msg_data,
    output logic          err
);
    localparam int CW = $clog2(MAX_SEQ + 1);

    logic          p_done, p_flush;
    logic [AW-1:0] p_addr;
    logic [CW-1:0] p_cnt;
    logic          s_evt, s_clash, s_abs, s_room;
    msg_kind_e     s_kind, o_type;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_data;

    trc_prog_tracker #(.AW(AW), .MAX_SEQ(MAX_SEQ), .CW(CW)) u_prog (
        .clk(clk), .rst_n(rst_n), .en(trace_en),
        .ret(ret_vld), .br(ret_branch), .tgt(ret_target),
        .done(p_done), .flush(p_flush), .addr(p_addr), .cnt(p_cnt)
    );

    trc_side_encoder #(.AW(AW), .DW(DW), .IW(IW)) u_side (
        .clk(clk), .rst_n(rst_n), .en(trace_en),
        .dat_vld(mem_vld), .dat_wr(mem_write), .dat_addr(mem_addr), .dat_val(mem_data),
        .itm_vld(inst_vld), .itm_val(inst_value), .room(s_room),
        .evt(s_evt), .clash(s_clash), .kind(s_kind), .abs(s_abs),
        .addr(s_addr), .data(s_data)
    );

    trc_out_arbiter #(.AW(AW), .DW(DW)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .side_evt(s_evt), .side_clash(s_clash), .side_kind(s_kind), .side_abs(s_abs),
        .side_addr(s_addr), .side_data(s_data),
        .prog_evt(p_done), .prog_flush(p_flush), .prog_addr(p_addr), .prog_data(DW'(p_cnt)),
        .msg_ready(msg_ready), .side_room(s_room),
        .msg_valid(msg_valid), .msg_type(o_type), .msg_flag(msg_flag),
        .msg_addr(msg_addr), .msg_data(msg_data), .err(err)
    );

    assign msg_type = o_type;
endmodule

// File: rtl/trace_encoder_checker.sv
module trace_encoder_checker #(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int IW      = 16,
    parameter int MAX_SEQ = 500
) (
    input logic          clk,
    input logic          rst_n,
    input logic          trace_en,
    input logic          mem_vld,
    input logic          inst_vld,
    input logic [IW-1:0] inst_value,
    input logic          msg_ready,
    input logic          msg_valid,
    input logic [1:0]    msg_type,
    input logic          msg_flag,
    input logic [AW-1:0] msg_addr,
    input logic [DW-1:0] msg_data,
    input logic          err
);
    // R1: outputs quiet right after a reset cycle
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!msg_valid && !err));

    assert_branch_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_type == 2'b00 && !msg_flag) |-> (msg_data < DW'(MAX_SEQ)));

    assert_limit_msg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_type == 2'b00 && msg_flag) |-> (msg_data == DW'(MAX_SEQ) && msg_addr == '0));

    assert_instr_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_en && inst_vld && !mem_vld && !msg_valid) |=>
        (msg_valid && msg_type == 2'b11 && msg_data == DW'($past(inst_value))));

    assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=>
        (msg_valid && $stable(msg_type) && $stable(msg_flag) && $stable(msg_addr) && $stable(msg_data)));

    assert_clash_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_en && mem_vld && inst_vld) |=> err);

    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!trace_en && !msg_valid) |=> (!err && !msg_valid));
endmodule

bind trace_encoder trace_encoder_checker #(.AW(AW), .DW(DW), .IW(IW), .MAX_SEQ(MAX_SEQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .mem_vld(mem_vld), .inst_vld(inst_vld),
    .inst_value(inst_value), .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_type(msg_type),
    .msg_flag(msg_flag), .msg_addr(msg_addr), .msg_data(msg_data), .err(err)
);

// File: tb/trace_encoder_test.sv
module trace_encoder_test;
    localparam int AW = 32, DW = 32, IW = 16, MAX_SEQ = 500;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, trace_en, ret_vld, ret_branch, mem_vld, mem_write, inst_vld, msg_ready;
    logic [AW-1:0] ret_target, mem_addr;
    logic [DW-1:0] mem_data;
    logic [IW-1:0] inst_value;
    logic          msg_valid, msg_flag, err;
    logic [1:0]    msg_type;
    logic [AW-1:0] msg_addr;
    logic [DW-1:0] msg_data;

    trace_encoder #(.AW(AW), .DW(DW), .IW(IW), .MAX_SEQ(MAX_SEQ)) uut (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en),
        .ret_vld(ret_vld), .ret_branch(ret_branch), .ret_target(ret_target),
        .mem_vld(mem_vld), .mem_write(mem_write), .mem_addr(mem_addr), .mem_data(mem_data),
        .inst_vld(inst_vld), .inst_value(inst_value), .msg_ready(msg_ready),
        .msg_valid(msg_valid), .msg_type(msg_type), .msg_flag(msg_flag),
        .msg_addr(msg_addr), .msg_data(msg_data), .err(err)
    );

    logic [66:0] exp_q[$];
    string       tag_q[$];
    int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0;
    int seq = 0;
    logic [AW-1:0] mbase = '0;
    bit mbase_ok = 0;

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            mon_checks++;
            if (exp_q.size() == 0) begin
                mon_fails++;
                $display("FAIL unexpected message act=%h exp=none", {msg_type, msg_flag, msg_addr, msg_data});
            end else begin
                logic [66:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({msg_type, msg_flag, msg_addr, msg_data} !== e) begin
                    mon_fails++;
                    $display("FAIL %s act=%h exp=%h", t, {msg_type, msg_flag, msg_addr, msg_data}, e);
                end
            end
        end
    end

    task automatic check(input string req, input logic [66:0] act, input logic [66:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] t, input logic f, input logic [31:0] a,
                        input logic [31:0] d, input string tag);
        exp_q.push_back({t, f, a, d});
        tag_q.push_back(tag);
    endtask

    task automatic sync();
        @(posedge clk);
        #1;
    endtask

    task automatic model_data(input bit wr, input logic [31:0] a, input logic [31:0] v, input string tag);
        if (mbase_ok) push(wr ? 2'b01 : 2'b10, 1'b0, a - mbase, v, tag);
        else          push(wr ? 2'b01 : 2'b10, 1'b1, a, v, tag);
        mbase = a;
        mbase_ok = 1;
    endtask

    task automatic retire_plain(input int n);
        for (int i = 0; i < n; i++) begin
            ret_vld = 1; ret_branch = 0;
            if (trace_en) begin
                seq++;
                if (seq == MAX_SEQ) begin
                    push(2'b00, 1'b1, 32'h0, MAX_SEQ, "R3");
                    seq = 0;
                end
            end
            sync();
        end
        ret_vld = 0;
    endtask

    task automatic branch(input logic [31:0] tgt);
        ret_vld = 1; ret_branch = 1; ret_target = tgt;
        push(2'b00, 1'b0, tgt, seq, "R2");
        seq = 0;
        sync();
        ret_vld = 0; ret_branch = 0;
    endtask

    task automatic data(input bit wr, input logic [31:0] a, input logic [31:0] v, input bit keep, input string tag);
        mem_vld = 1; mem_write = wr; mem_addr = a; mem_data = v;
        if (keep) model_data(wr, a, v, tag);
        sync();
        mem_vld = 0;
    endtask

    task automatic instr(input logic [15:0] v, input bit keep, input string tag);
        inst_vld = 1; inst_value = v;
        if (keep) push(2'b11, 1'b0, 32'h0, {16'h0, v}, tag);
        sync();
        inst_vld = 0;
    endtask

    task automatic drain(input string req);
        repeat (4) sync();
        check(req, 67'(exp_q.size()), 67'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog expired act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1, fails + mon_fails + 1);
        $finish;
    end

    initial begin
        rst_n = 0; trace_en = 1; ret_vld = 0; ret_branch = 0; ret_target = '0;
        mem_vld = 0; mem_write = 0; mem_addr = '0; mem_data = '0;
        inst_vld = 0; inst_value = '0; msg_ready = 1;
        repeat (3) sync();
        @(negedge clk);
        check("R1 valid in reset", 67'(msg_valid), 67'd0);
        check("R1 err in reset", 67'(err), 67'd0);
        @(posedge clk); #1;
        rst_n = 1;
        @(negedge clk);
        check("R1 valid after reset", 67'(msg_valid), 67'd0);
        sync();

        // R2 + R7: three sequential retirements then a branch
        retire_plain(3);
        branch(32'h0000_1000);
        @(negedge clk);
        check("R7 valid one cycle after branch", 67'(msg_valid), 67'd1);
        sync();
        drain("R2 queue drained");

        // R4: absolute first, then deltas (positive and negative)
        data(1, 32'h0000_2000, 32'h0000_00AA, 1, "R4 first absolute");
        data(0, 32'h0000_2010, 32'h0000_00BB, 1, "R4 read delta");
        data(1, 32'h0000_1FF0, 32'h0000_00CC, 1, "R4 negative delta");
        // R5: instrumentation does not move the base
        instr(16'h5A5A, 1, "R5 instr value");
        data(1, 32'h0000_2000, 32'h0000_00DD, 1, "R5 base untouched");
        drain("R4 R5 queue drained");

        // R6: same-cycle data write and branch, data first
        retire_plain(2);
        ret_vld = 1; ret_branch = 1; ret_target = 32'h0000_4000;
        mem_vld = 1; mem_write = 1; mem_addr = 32'h0000_2040; mem_data = 32'h1234_5678;
        model_data(1, 32'h0000_2040, 32'h1234_5678, "R6 side first");
        push(2'b00, 1'b0, 32'h0000_4000, 2, "R6 program second");
        seq = 0;
        sync();
        ret_vld = 0; ret_branch = 0; mem_vld = 0;
        drain("R6 queue drained");

        // R3: count limit
        retire_plain(MAX_SEQ);
        retire_plain(2);
        branch(32'h0000_5000);
        drain("R3 queue drained");

        // R8: stall holds the message
        msg_ready = 0;
        instr(16'h1234, 1, "R8 released message");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R8 held message", {msg_valid, msg_type, msg_data},
                  {1'b1, 2'b11, 32'h0000_1234, 32'h0}  >> 32);
            sync();
        end
        msg_ready = 1;
        drain("R8 queue drained");

        // R9: drops while stalled
        msg_ready = 0;
        instr(16'hAAAA, 1, "R9 kept instr");
        instr(16'hBBBB, 0, "");
        @(negedge clk);
        check("R9 err on full side slot", 67'(err), 67'd1);
        sync();
        data(1, 32'h0000_9000, 32'h0, 0, "");
        @(negedge clk);
        check("R9 err on dropped data", 67'(err), 67'd1);
        sync();
        msg_ready = 1;
        drain("R9 stalled drain");
        data(1, 32'h0000_2100, 32'h0000_0011, 1, "R9 base unchanged by drop");
        // same-cycle data and instrumentation
        mem_vld = 1; mem_write = 0; mem_addr = 32'h0000_2104; mem_data = 32'h0000_0022;
        inst_vld = 1; inst_value = 16'hCCCC;
        model_data(0, 32'h0000_2104, 32'h0000_0022, "R9 clash keeps data");
        sync();
        mem_vld = 0; inst_vld = 0;
        @(negedge clk);
        check("R9 err on clash", 67'(err), 67'd1);
        sync();
        drain("R9 queue drained");

        // R10: disabled trace ignores events and clears state
        retire_plain(3);
        trace_en = 0;
        seq = 0; mbase_ok = 0;
        sync();
        retire_plain(2);
        data(1, 32'h0000_7000, 32'h0, 0, "");
        instr(16'h7777, 0, "");
        @(negedge clk);
        check("R10 no message while disabled", {msg_valid, err}, 67'd0);
        sync();
        trace_en = 1;
        data(1, 32'h0000_3000, 32'h0000_0033, 1, "R10 absolute after enable");
        retire_plain(1);
        branch(32'h0000_6000);
        drain("R10 queue drained");

        $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, fails + mon_fails);
        $finish;
    end
endmodule